// File: doc/BRIEF.md
# Priority Interrupt Concentrator

This block gathers a set of active-high interrupt request lines onto one interrupt output that goes to a processor. Each line has its own enable bit. The output is high whenever at least one enabled line is high. Software finds out which line to service by reading an index register. That register returns the number of the lowest-numbered line that is both requesting and enabled, so lower numbers always take precedence.

The block is a target on a simple register bus. A request carries a valid strobe, a write flag, an address and write data. Exactly one cycle later a response comes back with read data and an error flag. The block owns an 8-byte window whose base is a parameter aligned to 8 bytes. Every access outside that window gets an error response, so the block can also be placed as the default target that answers decode misses.

Top module: `irq_concentrator`

## Requirements
- R1: After synchronous active-low reset the enable mask is zero, `irq_out` is low whatever `irq_in` is, and `rsp_valid` is low.
- R2: `irq_out` is combinationally the OR over all lines of `irq_in[i]` AND enable bit i. Each enable bit is bit i of the mask register.
- R3: The mask register is at window offset 4 (address bits [2:0] = 3'b100) and is readable and writable. Bits at or above `N_IRQ` are dropped on write and read as 0. Writing 0 disables every line.
- R4: A read at offset 0 (address bits [2:0] = 3'b000) returns the smallest i for which `irq_in[i]` and enable bit i are both 1.
- R5: When no enabled line is requesting, a read at offset 0 returns 32.
- R6: Every cycle with `req_valid` high is followed in the next cycle by `rsp_valid` high. `rsp_valid` is low in the cycle after one with no request.
- R7: Any access whose address bits above bit 2 differ from those of `SEG_BASE` gets `rsp_error` = 1 and changes no state.
- R8: A write at offset 0 gets `rsp_error` = 1 and leaves the mask unchanged.
- R9: An access inside the window at an offset other than 0 or 4 gets `rsp_error` = 1 and changes no state.
- R10: Every error response and every write response carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_error | output | 1 | The request was refused |
| irq_in | input | N_IRQ | Interrupt request lines, active high, already synchronous |
| irq_out | output | 1 | Merged interrupt, active high |

## Verification
The assertions check on every cycle that a response follows each request, and that refused accesses carry zero data and leave the mask alone. They also check that the reported index points at a pending line with no pending line below it, and that the "none" value 32 coincides exactly with a low `irq_out`. Only the bench's scenarios can show that the index value is actually correct and that the mask reads back what was written. It sweeps every mask against every input pattern of a six-line instance. The bench also covers the misdecoded offsets and addresses just outside the window on either side.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the interrupt concentrator.
// Assumes a 32-bit data path and an 8-byte register window.
package irqc_pkg;
    localparam int unsigned IRQC_DATA_W    = 32;
    localparam int unsigned IRQC_MAX_LINES = 32;
    localparam logic [2:0]  OFS_INDEX      = 3'h0;
    localparam logic [2:0]  OFS_MASK       = 3'h4;
    localparam logic [IRQC_DATA_W-1:0] IDX_NONE = 32'd32;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     hit;      // address lies inside the window
        reg_sel_e sel;      // register addressed
        logic     err;      // access must be refused
        logic     mask_we;  // accepted write to the mask
    } dec_t;
endpackage

// File: rtl/irqc_decode.sv
// Address decoder: matches the request against the 8-byte window and picks
// the register. Assumes SEG_BASE is a multiple of 8 and ADDR_W > 3.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] SEG_BASE = '0
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output dec_t              dec
);
    logic [2:0] offset;
    assign offset = req_addr[2:0];

    // Window match, register select and refusal rules.
    always_comb begin
        dec.hit = (req_addr[ADDR_W-1:3] == SEG_BASE[ADDR_W-1:3]);
        if (!dec.hit)                dec.sel = SEL_NONE;
        else if (offset == OFS_INDEX) dec.sel = SEL_INDEX;
        else if (offset == OFS_MASK)  dec.sel = SEL_MASK;
        else                          dec.sel = SEL_NONE;
        dec.err     = (dec.sel == SEL_NONE) ||
                      ((dec.sel == SEL_INDEX) && req_write);
        dec.mask_we = req_valid && req_write && (dec.sel == SEL_MASK);
    end
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority encoder: the lowest set bit of the pending vector wins.
// Produces IDX_NONE (32) when no bit is set. Purely combinational.
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int unsigned N_IRQ = 32
) (
    input  logic [N_IRQ-1:0]       pending,
    output logic [IRQC_DATA_W-1:0] idx_value
);
    // Scan downward so that the lowest pending index is the last written.
    always_comb begin
        idx_value = IDX_NONE;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pending[i]) idx_value = IRQC_DATA_W'(i);
        end
    end
endmodule

// File: rtl/irqc_regs.sv
// Mask register and registered response path. A response is produced exactly
// one cycle after each request; refused and write accesses return zero data.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned N_IRQ = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [IRQC_DATA_W-1:0] req_wdata,
    input  dec_t                   dec,
    input  logic [IRQC_DATA_W-1:0] idx_value,
    output logic [N_IRQ-1:0]       mask_q,
    output logic                   rsp_valid,
    output logic [IRQC_DATA_W-1:0] rsp_rdata,
    output logic                   rsp_error
);
    logic [IRQC_DATA_W-1:0] mask_ext;
    assign mask_ext = IRQC_DATA_W'(mask_q);

    // Mask register: cleared by reset, loaded by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= '0;
        else if (dec.mask_we) mask_q <= req_wdata[N_IRQ-1:0];
    end

    // Response register: strobe, error flag and read data one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_error <= req_valid && dec.err;
            if (req_valid && !dec.err && !req_write)
                rsp_rdata <= (dec.sel == SEL_INDEX) ? idx_value : mask_ext;
            else
                rsp_rdata <= '0;
        end
    end

    assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_outside_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dec.hit) |=> rsp_error);
    assert_refused_keeps_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec.err) |=> $stable(mask_q));
    assert_error_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_rdata == '0));
endmodule

// File: rtl/irq_concentrator.sv
// Top level: gates each request line with its enable bit, ORs the result onto
// irq_out and serves the index and mask registers over the request bus.
// Assumes irq_in is synchronous to clk and 1 <= N_IRQ <= 32.
module irq_concentrator
    import irqc_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] SEG_BASE = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [IRQC_DATA_W-1:0] req_wdata,
    output logic                   rsp_valid,
    output logic [IRQC_DATA_W-1:0] rsp_rdata,
    output logic                   rsp_error,
    input  logic [N_IRQ-1:0]       irq_in,
    output logic                   irq_out
);
    localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    dec_t                   dec;
    logic [N_IRQ-1:0]       mask_q;
    logic [N_IRQ-1:0]       pending;
    logic [IRQC_DATA_W-1:0] idx_value;

    irqc_decode #(.ADDR_W(ADDR_W), .SEG_BASE(SEG_BASE)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    // Per-line gating of each request by its enable bit.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_gate
        assign pending[g] = irq_in[g] & mask_q[g];
    end

    assign irq_out = |pending;

    irqc_prio #(.N_IRQ(N_IRQ)) u_prio (
        .pending   (pending),
        .idx_value (idx_value)
    );

    irqc_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .dec       (dec),
        .idx_value (idx_value),
        .mask_q    (mask_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_error (rsp_error)
    );

    logic [IDX_W-1:0] win;
    logic [N_IRQ-1:0] below;
    assign win   = idx_value[IDX_W-1:0];
    assign below = pending & ((N_IRQ'(1) << win) - N_IRQ'(1));

    assert_none_iff_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_value == IDX_NONE) == !irq_out);
    assert_winner_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_value != IDX_NONE) |-> (pending[win] && (below == '0)));
    assert_index_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_value < IRQC_DATA_W'(N_IRQ)) || (idx_value == IDX_NONE));
endmodule

// File: tb/sim_irq_concentrator.sv
// Sweeps every mask against every input pattern of a six-line instance and
// probes the refusal rules; expected values are computed arithmetically.
module sim_irq_concentrator;
    localparam int unsigned N      = 6;
    localparam int unsigned AW     = 16;
    localparam logic [AW-1:0] BASE = 16'h2A38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_error;
    logic [N-1:0]  irq_in = '0;
    logic          irq_out;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    irq_concentrator #(.N_IRQ(N), .ADDR_W(AW), .SEG_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus access; response sampled at the following falling edge.
    task automatic access(input logic wr, input logic [AW-1:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata; err = rsp_error; vld = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] expect_idx(input logic [N-1:0] p);
        for (int i = 0; i < int'(N); i++) if (p[i]) return 32'(i);
        return 32'd32;
    endfunction

    task automatic read_mask_expect(input string req, input logic [31:0] exp);
        logic [31:0] rd; logic err, vld;
        access(1'b0, BASE + 16'd4, 32'h0, rd, err, vld);
        check({req, " mask readback"}, rd, exp);
        check({req, " mask read error"}, 32'(err), 32'd0);
    endtask

    task automatic refused(input string req, input logic wr, input logic [AW-1:0] addr,
                           input logic [31:0] wd);
        logic [31:0] rd; logic err, vld;
        access(wr, addr, wd, rd, err, vld);
        check({req, " error flag"}, 32'(err), 32'd1);
        check({req, " R10 error data"}, rd, 32'd0);
        check({req, " R6 response strobe"}, 32'(vld), 32'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [31:0] rd; logic err, vld;
        repeat (3) @(negedge clk);
        irq_in = '1;
        @(negedge clk);
        // R1: reset state with every line raised
        check("R1 irq_out in reset", 32'(irq_out), 32'd0);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_out after reset", 32'(irq_out), 32'd0);
        check("R6 idle rsp_valid", 32'(rsp_valid), 32'd0);
        read_mask_expect("R1", 32'd0);

        // R2 R3 R4 R5: exhaustive sweep of mask x inputs
        for (int m = 0; m < 64; m++) begin
            access(1'b1, BASE + 16'd4, 32'hFFFF_FFC0 | 32'(m), rd, err, vld);
            check("R10 write data", rd, 32'd0);
            check("R3 write accepted", 32'(err), 32'd0);
            read_mask_expect("R3", 32'(m));
            for (int v = 0; v < 64; v++) begin
                logic [N-1:0] p;
                irq_in = N'(v);
                p = N'(v) & N'(m);
                #1;
                check("R2 irq_out", 32'(irq_out), 32'(|p));
                access(1'b0, BASE, 32'h0, rd, err, vld);
                check(p == '0 ? "R5 index none" : "R4 index", rd, expect_idx(p));
                check("R6 index response strobe", 32'(vld), 32'd1);
            end
        end
        @(negedge clk);
        check("R6 idle after traffic", 32'(rsp_valid), 32'd0);

        // Refusals, each followed by a mask readback (mask is 6'h3F here)
        refused("R7 below window", 1'b0, BASE - 16'd8, 32'h0);
        refused("R7 above window", 1'b0, BASE + 16'd8, 32'h0);
        refused("R7 write above window", 1'b1, BASE + 16'd12, 32'h0);
        read_mask_expect("R7", 32'h3F);
        refused("R7 write far away", 1'b1, 16'h0004, 32'h0);
        read_mask_expect("R7", 32'h3F);
        refused("R8 write index", 1'b1, BASE, 32'h0);
        read_mask_expect("R8", 32'h3F);
        for (int o = 1; o < 8; o++) begin
            if (o != 4) begin
                refused("R9 bad offset read", 1'b0, BASE + AW'(o), 32'h0);
                refused("R9 bad offset write", 1'b1, BASE + AW'(o), 32'h0);
            end
        end
        read_mask_expect("R9", 32'h3F);

        // R3: writing zero disables all lines
        irq_in = '1;
        access(1'b1, BASE + 16'd4, 32'h0, rd, err, vld);
        read_mask_expect("R3 clear", 32'd0);
        check("R3 irq_out after clear", 32'(irq_out), 32'd0);
        access(1'b0, BASE, 32'h0, rd, err, vld);
        check("R5 index after clear", rd, 32'd32);

        // R1: reset again clears a non-zero mask
        access(1'b1, BASE + 16'd4, 32'h15, rd, err, vld);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_out after second reset", 32'(irq_out), 32'd0);
        read_mask_expect("R1 second reset", 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule